// File: doc/BRIEF.md
# Dynamic predication mode controller

This front-end control unit decides when the fetch stage leaves single-path operation and fetches both directions of a compiler-marked branch whose direction is uncertain. When such a branch arrives with a low-confidence flag and a predicate register id is free, the controller computes where the two paths rejoin. The rejoin address is the branch PC plus the relative offset that travels with the branch. The controller latches that address, pulses a fork strobe that copies the return stack, global history and rename table, and hands out a predicate register id.

While the mode is active, the controller picks which path gets each fetch slot. It alternates between the predicted path and the alternate path. A path whose fetch PC has reached the rejoin address gets no more slots. The mode ends when both paths have rejoined or the uncertain branch resolves. It also ends early when too many instructions have been fetched. A younger uncertain branch on the predicted path ends the mode too, and the mode then restarts at that branch. Each exit pulses a restore strobe and reports a two-bit reason code.

Top module: `dpred_ctrl`

## Requirements
- R1: The two-bit branch marker `br_mark` is decoded as 2'b00 = ordinary branch, 2'b10 = forward diverge branch, 2'b11 = loop diverge branch; 2'b01 is treated as ordinary; only the two diverge codes can start the mode.
- R2: The mode starts on a clock edge where `br_valid` is high, the marker is a diverge code, `br_lowconf` is high and an id is free. `fork_o` is high for exactly the next cycle, and `mode_active` is high from that cycle on. A high-confidence diverge branch never starts the mode.
- R3: From the cycle after entry, `merge_pc` equals `br_pc + br_off` (offset zero-extended, sum modulo 2^PCW).
- R4: Each entry takes the lowest-numbered free id out of 32 and shows it on `pred_id` until the next entry. An id stays taken until `rel_valid` returns it. With all 32 ids taken, a low-confidence diverge branch is handled as ordinary: no fork, and the mode does not start.
- R5: In the first active cycle `fetch_sel` is 0 (predicted path). It then alternates 1, 0, 1 … on each active cycle while neither path has reached `merge_pc`.
- R6: Once `pred_pc` equals `merge_pc` (that cycle or any earlier cycle of the mode), `fetch_sel` is 1. Once `alt_pc` has done so, and the predicted path has not, `fetch_sel` is 0.
- R7: When both paths have reached `merge_pc`, the next cycle shows `exit_valid`=1 with `exit_reason`=0 (merged), and `mode_active`=0.
- R8: `div_resolve` during the mode gives an exit with `exit_reason`=1 (resolved) in the next cycle. It outranks every other exit cause.
- R9: Each cycle of the mode after the entry cycle adds `fetch_n` to a count. When the count exceeds `cnt_limit`, the next cycle shows an exit with `exit_reason`=2 (counter). A count exactly equal to the limit does not exit.
- R10: A low-confidence diverge branch that arrives during the mode while an id is free gives an exit with `exit_reason`=3 (yield). In the same cycle `fork_o` is 1, `mode_active` stays 1, `merge_pc` is recomputed from the younger branch, and a new id is given out. A high-confidence branch during the mode changes nothing.
- R11: Every exit is a one-cycle `exit_valid` pulse together with a `restore_o` pulse. Priority is resolved > merged > yield > counter.
- R12: After reset `mode_active`, `fork_o`, `restore_o`, `exit_valid` and `fetch_sel` are 0, and all 32 ids are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A decoded branch on the predicted path this cycle |
| br_mark | input | 2 | Compiler marker of that branch |
| br_pc | input | PCW | PC of that branch |
| br_off | input | OFFW | Relative offset to its rejoin point |
| br_lowconf | input | 1 | Confidence estimator flags the branch as uncertain |
| pred_pc | input | PCW | Current fetch PC of the predicted path |
| alt_pc | input | PCW | Current fetch PC of the alternate path |
| div_resolve | input | 1 | The uncertain branch has resolved |
| fetch_n | input | FNW | Instructions fetched this cycle |
| cnt_limit | input | CW | Fetch-count threshold for early exit |
| rel_valid | input | 1 | Return a predicate id to the free pool |
| rel_id | input | 5 | Id being returned |
| mode_active | output | 1 | Two-path fetch mode is on |
| merge_pc | output | PCW | Latched rejoin address |
| fork_o | output | 1 | Copy return stack, history and rename table |
| restore_o | output | 1 | Return those structures to single-path state |
| pred_id | output | 5 | Predicate register id of the current mode |
| fetch_sel | output | 1 | 0 = predicted path fetches, 1 = alternate path fetches |
| exit_valid | output | 1 | The mode ended on the last edge |
| exit_reason | output | 2 | 0 merged, 1 resolved, 2 counter, 3 yield |

## Verification
A table of branch vectors covers each marker code, both confidence levels and a rejoin address that wraps past the top of the PC space. This separates correct decoding and address arithmetic from the cases that must leave the front end alone. Directed sequences then let the two paths reach the rejoin point at different times, which tells alternation apart from slot steering. A fetch count that lands exactly on the limit and then passes it separates "exceeds" from "reaches". A yield with a younger branch, a resolve in the same cycle as a double merge, and the use of all 32 ids check priority, re-entry and the fallback to ordinary handling.

// File: rtl/dpred_ctrl.sv
module dpred_ctrl #(
  parameter int PCW   = 16,
  parameter int OFFW  = 12,
  parameter int NPRED = 32,
  parameter int CW    = 10,
  parameter int FNW   = 3,
  localparam int IDW  = $clog2(NPRED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [1:0]      br_mark,
  input  logic [PCW-1:0]  br_pc,
  input  logic [OFFW-1:0] br_off,
  input  logic            br_lowconf,
  input  logic [PCW-1:0]  pred_pc,
  input  logic [PCW-1:0]  alt_pc,
  input  logic            div_resolve,
  input  logic [FNW-1:0]  fetch_n,
  input  logic [CW-1:0]   cnt_limit,
  input  logic            rel_valid,
  input  logic [IDW-1:0]  rel_id,
  output logic            mode_active,
  output logic [PCW-1:0]  merge_pc,
  output logic            fork_o,
  output logic            restore_o,
  output logic [IDW-1:0]  pred_id,
  output logic            fetch_sel,
  output logic            exit_valid,
  output logic [1:0]      exit_reason
);

  logic [NPRED-1:0] free_q;
  logic             p_done, a_done, rr;
  logic [CW-1:0]    cnt_q;
  logic [IDW-1:0]   alloc_id;

  wire is_div   = br_valid & br_lowconf & ((br_mark == 2'b10) | (br_mark == 2'b11));
  wire any_free = |free_q;
  wire take     = is_div & any_free;
  wire [PCW-1:0] new_merge = br_pc + PCW'(br_off);

  wire p_now = p_done | (pred_pc == merge_pc);
  wire a_now = a_done | (alt_pc == merge_pc);
  wire [CW:0] cnt_nxt = {1'b0, cnt_q} + (CW+1)'(fetch_n);

  wire ex_res = mode_active & div_resolve;
  wire ex_mrg = mode_active & p_now & a_now;
  wire ex_yld = mode_active & take;
  wire ex_cnt = mode_active & (cnt_nxt > {1'b0, cnt_limit});
  wire ex_any = ex_res | ex_mrg | ex_yld | ex_cnt;
  wire enter  = take & ~ex_res & ~ex_mrg;

  logic [1:0] rsn;
  always_comb begin
    if (ex_res)      rsn = 2'd1;
    else if (ex_mrg) rsn = 2'd0;
    else if (ex_yld) rsn = 2'd3;
    else             rsn = 2'd2;
  end

  always_comb begin
    alloc_id = '0;
    for (int i = NPRED - 1; i >= 0; i--)
      if (free_q[i]) alloc_id = IDW'(i);
  end

  wire [NPRED-1:0] rel_mask   = rel_valid ? (NPRED'(1) << rel_id) : '0;
  wire [NPRED-1:0] alloc_mask = enter ? (NPRED'(1) << alloc_id) : '0;

  assign fetch_sel = mode_active & (p_now | (~a_now & rr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_active <= 1'b0;
      merge_pc    <= '0;
      pred_id     <= '0;
      p_done      <= 1'b0;
      a_done      <= 1'b0;
      rr          <= 1'b0;
      cnt_q       <= '0;
      free_q      <= '1;
      fork_o      <= 1'b0;
      restore_o   <= 1'b0;
      exit_valid  <= 1'b0;
      exit_reason <= 2'd0;
    end else begin
      fork_o     <= enter;
      restore_o  <= ex_any;
      exit_valid <= ex_any;
      if (ex_any) exit_reason <= rsn;
      free_q <= (free_q | rel_mask) & ~alloc_mask;
      if (enter) begin
        mode_active <= 1'b1;
        merge_pc    <= new_merge;
        pred_id     <= alloc_id;
        p_done      <= 1'b0;
        a_done      <= 1'b0;
        rr          <= 1'b0;
        cnt_q       <= '0;
      end else if (ex_any) begin
        mode_active <= 1'b0;
        p_done      <= 1'b0;
        a_done      <= 1'b0;
      end else if (mode_active) begin
        p_done <= p_now;
        a_done <= a_now;
        rr     <= ~rr;
        cnt_q  <= cnt_nxt[CW-1:0];
      end
    end
  end

endmodule

// File: rtl/dpred_ctrl_chk.sv
module dpred_ctrl_chk #(
  parameter int PCW  = 16,
  parameter int OFFW = 12,
  parameter int IDW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_valid,
  input logic [1:0]      br_mark,
  input logic [PCW-1:0]  br_pc,
  input logic [OFFW-1:0] br_off,
  input logic            br_lowconf,
  input logic [PCW-1:0]  pred_pc,
  input logic            div_resolve,
  input logic            mode_active,
  input logic [PCW-1:0]  merge_pc,
  input logic            fork_o,
  input logic            restore_o,
  input logic [IDW-1:0]  pred_id,
  input logic            fetch_sel,
  input logic            exit_valid,
  input logic [1:0]      exit_reason
);

  p_fork_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fork_o |-> $past(br_valid && br_lowconf && (br_mark == 2'b10 || br_mark == 2'b11)));

  p_fork_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fork_o |-> mode_active);

  p_merge_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fork_o |-> (merge_pc == $past(br_pc) + PCW'($past(br_off))));

  p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active && $past(mode_active) && !fork_o) |-> $stable(pred_id));

  p_merged_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active && pred_pc == merge_pc) |-> fetch_sel);

  p_idle_no_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_active) |-> !exit_valid);

  p_resolve_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_valid && exit_reason == 2'd1) |-> $past(div_resolve && mode_active));

  p_yield_refork_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_valid && exit_reason == 2'd3) |-> (fork_o && mode_active));

  p_exit_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |-> restore_o);

endmodule

bind dpred_ctrl dpred_ctrl_chk #(.PCW(PCW), .OFFW(OFFW), .IDW(IDW)) chk_i (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_mark(br_mark),
  .br_pc(br_pc), .br_off(br_off), .br_lowconf(br_lowconf), .pred_pc(pred_pc),
  .div_resolve(div_resolve), .mode_active(mode_active), .merge_pc(merge_pc),
  .fork_o(fork_o), .restore_o(restore_o), .pred_id(pred_id),
  .fetch_sel(fetch_sel), .exit_valid(exit_valid), .exit_reason(exit_reason)
);

// File: tb/dpred_ctrl_tb.sv
`timescale 1ns/1ps
module dpred_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [1:0]  br_mark = 2'b00;
  logic [15:0] br_pc = '0;
  logic [11:0] br_off = '0;
  logic        br_lowconf = 1'b0;
  logic [15:0] pred_pc = 16'hFFFE;
  logic [15:0] alt_pc = 16'hFFFE;
  logic        div_resolve = 1'b0;
  logic [2:0]  fetch_n = '0;
  logic [9:0]  cnt_limit = '1;
  logic        rel_valid = 1'b0;
  logic [4:0]  rel_id = '0;
  logic        mode_active, fork_o, restore_o, fetch_sel, exit_valid;
  logic [15:0] merge_pc;
  logic [4:0]  pred_id;
  logic [1:0]  exit_reason;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dpred_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_mark(br_mark),
    .br_pc(br_pc), .br_off(br_off), .br_lowconf(br_lowconf),
    .pred_pc(pred_pc), .alt_pc(alt_pc), .div_resolve(div_resolve),
    .fetch_n(fetch_n), .cnt_limit(cnt_limit), .rel_valid(rel_valid),
    .rel_id(rel_id), .mode_active(mode_active), .merge_pc(merge_pc),
    .fork_o(fork_o), .restore_o(restore_o), .pred_id(pred_id),
    .fetch_sel(fetch_sel), .exit_valid(exit_valid), .exit_reason(exit_reason)
  );

  localparam int NV = 7;
  localparam logic [1:0]  V_MARK [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b10, 2'b11, 2'b10};
  localparam logic        V_LOW  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] V_PC   [NV] = '{16'h1000, 16'h1000, 16'h1000, 16'h2000, 16'h1000, 16'hFFF0, 16'h0ABC};
  localparam logic [11:0] V_OFF  [NV] = '{12'h010, 12'h010, 12'h024, 12'h008, 12'h024, 12'h020, 12'h100};
  localparam logic        V_ENT  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] V_MRG  [NV] = '{16'h0, 16'h0, 16'h1024, 16'h2008, 16'h0, 16'h0010, 16'h0BBC};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive_br(input logic [1:0] m, input logic lc, input logic [15:0] pc, input logic [11:0] off);
    br_valid = 1'b1; br_mark = m; br_lowconf = lc; br_pc = pc; br_off = off;
  endtask

  task automatic release_id(input logic [4:0] id);
    rel_valid = 1'b1; rel_id = id;
    tick();
    rel_valid = 1'b0;
  endtask

  task automatic resolve_now();
    div_resolve = 1'b1;
    tick();
    div_resolve = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R12 reset mode_active", 32'(mode_active), 0);
    chk("R12 reset fork", 32'(fork_o), 0);
    chk("R12 reset restore", 32'(restore_o), 0);
    chk("R12 reset exit_valid", 32'(exit_valid), 0);
    chk("R12 reset fetch_sel", 32'(fetch_sel), 0);

    // R1 R2 R3: vector table of markers, confidence and address wrap
    for (int v = 0; v < NV; v++) begin
      drive_br(V_MARK[v], V_LOW[v], V_PC[v], V_OFF[v]);
      tick();
      br_valid = 1'b0;
      chk("R1 R2 fork on entry", 32'(fork_o), 32'(V_ENT[v]));
      chk("R2 mode_active", 32'(mode_active), 32'(V_ENT[v]));
      if (V_ENT[v]) begin
        chk("R3 merge_pc", 32'(merge_pc), 32'(V_MRG[v]));
        chk("R4 lowest id", 32'(pred_id), 0);
        resolve_now();
        chk("R8 resolved exit", 32'(exit_valid), 1);
        chk("R8 reason", 32'(exit_reason), 1);
        chk("R11 restore", 32'(restore_o), 1);
        chk("R8 inactive", 32'(mode_active), 0);
        release_id(5'd0);
        chk("R11 exit one pulse", 32'(exit_valid), 0);
      end else begin
        tick();
      end
    end

    // R5 R6 R7: alternation, steering, merge exit
    pred_pc = 16'h0104; alt_pc = 16'h0200;
    drive_br(2'b10, 1'b1, 16'h0100, 12'h040);
    tick(); br_valid = 1'b0; #1;
    chk("R5 first slot predicted", 32'(fetch_sel), 0);
    tick(); #1;
    chk("R5 second slot alternate", 32'(fetch_sel), 1);
    tick(); #1;
    chk("R5 third slot predicted", 32'(fetch_sel), 0);
    pred_pc = 16'h0140; #1;
    chk("R6 predicted merged steers", 32'(fetch_sel), 1);
    tick();
    pred_pc = 16'h0150; #1;
    chk("R6 steering held", 32'(fetch_sel), 1);
    chk("R7 still active", 32'(mode_active), 1);
    alt_pc = 16'h0140;
    tick();
    chk("R7 merged exit", 32'(exit_valid), 1);
    chk("R7 reason merged", 32'(exit_reason), 0);
    chk("R7 inactive", 32'(mode_active), 0);
    pred_pc = 16'hFFFE; alt_pc = 16'hFFFE;
    release_id(5'd0);

    // R6 alternate merged first
    pred_pc = 16'h0104; alt_pc = 16'h0200;
    drive_br(2'b11, 1'b1, 16'h0100, 12'h040);
    tick(); br_valid = 1'b0;
    alt_pc = 16'h0140; #1;
    chk("R6 alternate merged steers", 32'(fetch_sel), 0);
    tick(); alt_pc = 16'h0180; #1;
    chk("R6 alternate steering held", 32'(fetch_sel), 0);
    resolve_now();
    pred_pc = 16'hFFFE; alt_pc = 16'hFFFE;
    release_id(5'd0);

    // R9 counter policy with boundary
    cnt_limit = 10'd8; fetch_n = 3'd4;
    drive_br(2'b10, 1'b1, 16'h0200, 12'h010);
    tick(); br_valid = 1'b0;
    tick();
    chk("R9 count 4 active", 32'(mode_active), 1);
    tick();
    chk("R9 count equal limit no exit", 32'(exit_valid), 0);
    tick();
    chk("R9 counter exit", 32'(exit_valid), 1);
    chk("R9 reason counter", 32'(exit_reason), 2);
    chk("R9 inactive", 32'(mode_active), 0);
    cnt_limit = '1; fetch_n = '0;
    release_id(5'd0);

    // R10 yield
    drive_br(2'b10, 1'b1, 16'h0300, 12'h020);
    tick();
    chk("R10 first merge", 32'(merge_pc), 32'h0320);
    drive_br(2'b10, 1'b0, 16'h0310, 12'h008);
    tick();
    chk("R10 high confidence ignored exit", 32'(exit_valid), 0);
    chk("R10 high confidence ignored merge", 32'(merge_pc), 32'h0320);
    drive_br(2'b11, 1'b1, 16'h0310, 12'h008);
    tick(); br_valid = 1'b0;
    chk("R10 yield exit", 32'(exit_valid), 1);
    chk("R10 reason yield", 32'(exit_reason), 3);
    chk("R10 refork", 32'(fork_o), 1);
    chk("R10 stays active", 32'(mode_active), 1);
    chk("R10 new merge", 32'(merge_pc), 32'h0318);
    chk("R10 new id", 32'(pred_id), 1);
    resolve_now();
    release_id(5'd0);
    release_id(5'd1);

    // R11 priority: resolve beats merge
    drive_br(2'b10, 1'b1, 16'h0500, 12'h010);
    tick(); br_valid = 1'b0;
    pred_pc = 16'h0510; alt_pc = 16'h0510; div_resolve = 1'b1;
    tick(); div_resolve = 1'b0;
    chk("R11 priority resolve over merge", 32'(exit_reason), 1);
    pred_pc = 16'hFFFE; alt_pc = 16'hFFFE;
    release_id(5'd0);

    // R4 id exhaustion
    for (int i = 0; i < 32; i++) begin
      drive_br(2'b10, 1'b1, 16'h0400, 12'h004);
      tick(); br_valid = 1'b0;
      chk("R4 sequential id", 32'(pred_id), 32'(i));
      resolve_now();
    end
    drive_br(2'b10, 1'b1, 16'h0400, 12'h004);
    tick(); br_valid = 1'b0;
    chk("R4 no id no fork", 32'(fork_o), 0);
    chk("R4 no id no mode", 32'(mode_active), 0);
    release_id(5'd5);
    drive_br(2'b10, 1'b1, 16'h0400, 12'h004);
    tick(); br_valid = 1'b0;
    chk("R4 released id reused", 32'(pred_id), 5);
    resolve_now();
    for (int i = 0; i < 32; i++) release_id(5'(i));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule